// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block supervises software by counting clock cycles once it has been armed. Software proves it is alive by writing a fixed pair of key bytes, 0x55 and then 0xAA, to a dedicated service address. A single write strobe does not count as service. If the count reaches the selected period before a complete key pair arrives, the block raises a reset request for a fixed number of clocks.

A small control register sets the period. It holds an arm bit, a prescale-select bit and a two-bit range code. The range code picks one of four base periods spaced by a factor of four. The prescale bit stretches the chosen period by a further power of two. Setting the arm bit locks the whole control register until the next reset, so runaway code can neither stop the timer nor change its period.

After each reset-request pulse, the counter and the key tracker go back to their reset values. Counting then resumes with the same locked settings. All register access goes through one write port: address, byte data and a strobe.

Top module: `keyed_wdt`

## Requirements
- R1: After reset, rst_req is 0 and the block is disarmed. While disarmed, no reset request is ever produced, even if the control register has been written with the arm bit clear.
- R2: The control register sits at address 0 with bit 0 = arm, bit 1 = prescale select and bits 3:2 = range code. A write there that sets the arm bit at clock edge W, with prescale clear and range code c, makes rst_req rise after edge W + 2^(BASE_LOG2 + STEP_LOG2*c).
- R3: With the prescale bit set, the period of R2 is multiplied by 2^PRE_LOG2.
- R4: A write of 0x55 to the service address (1) followed by a write of 0xAA to that address restarts the period. rst_req then rises one full period after the edge that accepted 0xAA.
- R5: A lone 0xAA, or a lone 0x55 not followed by 0xAA, has no effect on when rst_req rises.
- R6: After 0x55, any other value written to the service address returns the tracker to idle without restarting the period. A following 0xAA then has no effect.
- R7: Writes to other addresses between 0x55 and 0xAA do not break the key pair.
- R8: rst_req stays high for exactly PULSE_LEN cycles. The counter then restarts from zero, so the next pulse rises PULSE_LEN plus one period after the previous rise.
- R9: Once armed, every write to the control register is ignored until reset, including writes that clear the arm bit or change the period.
- R10: The key pair counts only at the service address. 0xAA written to any other address does not complete a pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_addr | input | ADDR_W | Register address (0 control, 1 service) |
| wr_data | input | 8 | Write data byte |
| rst_req | output | 1 | Registered reset-request pulse |

## Verification
The embedded assertions check, on every cycle, that the arm bit and the locked settings never change after arming. They also check that the counter stays at zero while disarmed, that an accepted key pair zeroes the counter, and that a key mismatch returns the tracker to idle. Each rst_req pulse must be caused by an expiry and must last exactly PULSE_LEN cycles. The exact period for each range code and for the prescaler, and the restart point after a key pair, can only be shown by the bench's scenarios. The same holds for the ignored lone, broken and misaddressed keys, and for the spacing between consecutive pulses, because each of these depends on when the writes occur relative to the count.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_ARMED = 1'b1
  } kwdt_seq_e;

  typedef struct packed {
    logic [1:0] tsel;
    logic       psel;
    logic       en;
  } kwdt_cfg_t;

endpackage

// File: rtl/kwdt_ctrl_reg.sv
module kwdt_ctrl_reg
  import kwdt_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int CTRL_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output kwdt_cfg_t         cfg
);

  kwdt_cfg_t cfg_q;
  logic      ctrl_hit;
  logic [3:0] unused_hi;

  assign unused_hi = wr_data[7:4];
  assign ctrl_hit  = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR)) && !cfg_q.en;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (ctrl_hit) begin
      cfg_q <= kwdt_cfg_t'(wr_data[3:0]);
    end
  end

  assign cfg = cfg_q;

  AST_EN_STICKY: assert property (@(posedge clk) disable iff (rst)
    cfg_q.en |=> cfg_q.en); // R9

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (rst)
    cfg_q.en |=> $stable(cfg_q)); // R9

endmodule

// File: rtl/kwdt_key_seq.sv
module kwdt_key_seq
  import kwdt_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int SVC_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              hold,
  output logic              svc_ok
);

  kwdt_seq_e state_q, state_d;
  logic      svc_hit;

  assign svc_hit = wr_en && (wr_addr == ADDR_W'(SVC_ADDR)) && !hold;
  assign svc_ok  = svc_hit && (state_q == SEQ_ARMED) && (wr_data == KEY_SECOND);

  always_comb begin
    state_d = state_q;
    if (hold) begin
      state_d = SEQ_IDLE;
    end else if (svc_hit) begin
      if (state_q == SEQ_IDLE && wr_data == KEY_FIRST) begin
        state_d = SEQ_ARMED;
      end else begin
        state_d = SEQ_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  AST_PAIR_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    svc_ok |=> (state_q == SEQ_IDLE)); // R4

  AST_BAD_KEY_DISARMS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(SVC_ADDR) && state_q == SEQ_ARMED && wr_data != KEY_SECOND)
      |=> (state_q == SEQ_IDLE)); // R6

endmodule

// File: rtl/kwdt_timebase.sv
module kwdt_timebase #(
  parameter int BASE_LOG2 = 9,
  parameter int STEP_LOG2 = 2,
  parameter int PRE_LOG2  = 9
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       psel,
  input  logic [1:0] tsel,
  input  logic       clr,
  input  logic       hold,
  output logic       expire
);

  localparam int CNT_W = BASE_LOG2 + STEP_LOG2 * 3;

  logic [CNT_W-1:0] lim_tab [4];
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic             run;
  logic             tick;

  for (genvar c = 0; c < 4; c++) begin : g_lim
    localparam int SH = BASE_LOG2 + STEP_LOG2 * c;
    assign lim_tab[c] = CNT_W'((64'd1 << SH) - 64'd1);
  end

  assign lim    = lim_tab[tsel];
  assign run    = en && !hold;
  assign expire = run && tick && (cnt_q == lim) && !clr;

  if (PRE_LOG2 > 0) begin : g_pre
    logic [PRE_LOG2-1:0] pre_q;
    assign tick = !psel || (pre_q == '1);
    always_ff @(posedge clk) begin
      if (rst || clr || expire || !run) begin
        pre_q <= '0;
      end else if (psel) begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end else begin : g_nopre
    logic unused_psel;
    assign unused_psel = psel;
    assign tick = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || clr || expire || !run) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt_q == '0)); // R1

  AST_SVC_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0)); // R4

endmodule

// File: rtl/kwdt_pulse.sv
module kwdt_pulse #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  output logic rst_req,
  output logic busy
);

  localparam int PCNT_W = $clog2(PULSE_LEN + 1);
  localparam int RUN_W  = PCNT_W + 1;

  logic [PCNT_W-1:0] pcnt_q;
  logic              req_q;
  logic [RUN_W-1:0]  hi_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt_q <= '0;
      req_q  <= 1'b0;
    end else if (expire) begin
      pcnt_q <= PCNT_W'(PULSE_LEN);
      req_q  <= 1'b1;
    end else begin
      if (pcnt_q != '0) pcnt_q <= pcnt_q - 1'b1;
      req_q <= (pcnt_q > PCNT_W'(1));
    end
  end

  assign rst_req = req_q;
  assign busy    = (pcnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_run <= '0;
    end else begin
      hi_run <= req_q ? hi_run + 1'b1 : '0;
    end
  end

  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (rst)
    $fell(req_q) |-> (hi_run == RUN_W'(PULSE_LEN))); // R8

  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(req_q) |-> $past(expire)); // R2

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import kwdt_pkg::*;
#(
  parameter int ADDR_W    = 2,
  parameter int CTRL_ADDR = 0,
  parameter int SVC_ADDR  = 1,
  parameter int BASE_LOG2 = 9,
  parameter int STEP_LOG2 = 2,
  parameter int PRE_LOG2  = 9,
  parameter int PULSE_LEN = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              rst_req
);

  kwdt_cfg_t cfg;
  logic      svc_ok;
  logic      expire;
  logic      busy;

  kwdt_ctrl_reg #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg(cfg)
  );

  kwdt_key_seq #(.ADDR_W(ADDR_W), .SVC_ADDR(SVC_ADDR)) u_seq (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .hold(busy), .svc_ok(svc_ok)
  );

  kwdt_timebase #(.BASE_LOG2(BASE_LOG2), .STEP_LOG2(STEP_LOG2), .PRE_LOG2(PRE_LOG2)) u_tb (
    .clk(clk), .rst(rst), .en(cfg.en), .psel(cfg.psel), .tsel(cfg.tsel),
    .clr(svc_ok), .hold(busy), .expire(expire)
  );

  kwdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst(rst), .expire(expire), .rst_req(rst_req), .busy(busy)
  );

  AST_NO_REQ_DISARMED: assert property (@(posedge clk) disable iff (rst)
    !cfg.en |=> !rst_req); // R1

  AST_KEY_NEEDS_SVC_ADDR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != ADDR_W'(SVC_ADDR)) |-> !svc_ok); // R10

endmodule

// File: tb/keyed_wdt_tb_top.sv
module keyed_wdt_tb_top;

  localparam int BASE = 4;
  localparam int STEP = 2;
  localparam int PRE  = 3;
  localparam int PL   = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rst_req;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int pulses = 0;
  bit done = 0;

  int    exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  keyed_wdt #(.ADDR_W(2), .CTRL_ADDR(0), .SVC_ADDR(1), .BASE_LOG2(BASE),
              .STEP_LOG2(STEP), .PRE_LOG2(PRE), .PULSE_LEN(PL)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rst_req(rst_req)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  function automatic int period(input int code, input bit ps);
    return (1 << (BASE + STEP * code)) * (ps ? (1 << PRE) : 1);
  endfunction

  task automatic expect_rise(input int c, input string tag);
    exp_q.push_back(c);
    tag_q.push_back(tag);
  endtask

  // Monitor: pops expected rise cycles and checks pulse width.
  bit prev = 0;
  int hi_len = 0;
  always @(negedge clk) begin
    if (rst) begin
      prev = 0;
      hi_len = 0;
    end else begin
      if (rst_req && !prev) begin
        pulses++;
        if (exp_q.size() == 0) begin
          chk(0, "unexpected pulse R1/R5/R6", cyc, -1);
        end else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(cyc == e, t, cyc, e);
        end
      end
      if (rst_req) hi_len++;
      if (!rst_req && prev) begin
        chk(hi_len == PL, "R8 width", hi_len, PL);
        hi_len = 0;
      end
      prev = rst_req;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d, output int edge_no);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    edge_no = cyc + 1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic drain(input string req);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
    tag_q.delete();
  endtask

  initial begin
    int w, s, x, p, p0;
    do_reset();
    @(negedge clk);
    chk(rst_req == 1'b0, "R1 reset value", rst_req, 0);

    // R1: config written without arm bit -> never a pulse
    wr(2'd0, 8'h0C, w);
    p0 = pulses;
    wait_until(w + 1200);
    chk(pulses == p0, "R1 disarmed quiet", pulses, p0);

    // R2 / R8: each range code, two consecutive pulses
    for (int code = 0; code < 4; code++) begin
      do_reset();
      wr(2'd0, {4'b0, code[1:0], 1'b0, 1'b1}, w);
      p = period(code, 1'b0);
      expect_rise(w + p, "R2 range period");
      expect_rise(w + 2 * p + PL, "R8 restart spacing");
      wait_until(w + 2 * p + 2 * PL + 4);
      drain("R2 missing pulse");
    end

    // R3: prescale on codes 0 and 1
    for (int code = 0; code < 2; code++) begin
      do_reset();
      wr(2'd0, {4'b0, code[1:0], 1'b1, 1'b1}, w);
      p = period(code, 1'b1);
      expect_rise(w + p, "R3 prescaled period");
      wait_until(w + p + PL + 4);
      drain("R3 missing pulse");
    end

    // R4: valid key pair restarts the period
    do_reset();
    p = period(1, 1'b0);
    wr(2'd0, 8'h05, w);
    wait_until(w + 40);
    wr(2'd1, 8'h55, x);
    wr(2'd1, 8'hAA, s);
    expect_rise(s + p, "R4 restart after key pair");
    expect_rise(s + 2 * p + PL, "R8 spacing after key pair");
    wait_until(s + 2 * p + 2 * PL + 4);
    drain("R4 missing pulse");

    // R5: lone 0xAA, then lone 0x55
    do_reset();
    wr(2'd0, 8'h05, w);
    wait_until(w + 20);
    wr(2'd1, 8'hAA, x);
    wr(2'd1, 8'h55, x);
    expect_rise(w + p, "R5 lone keys ignored");
    wait_until(w + p + PL + 4);
    drain("R5 missing pulse");

    // R6: broken pair
    do_reset();
    wr(2'd0, 8'h05, w);
    wait_until(w + 30);
    wr(2'd1, 8'h55, x);
    wr(2'd1, 8'h12, x);
    wr(2'd1, 8'hAA, x);
    expect_rise(w + p, "R6 broken pair no restart");
    wait_until(w + p + PL + 4);
    drain("R6 missing pulse");

    // R7 + R9: control write between keys keeps the pair and is ignored
    do_reset();
    wr(2'd0, 8'h05, w);
    wait_until(w + 30);
    wr(2'd1, 8'h55, x);
    wr(2'd0, 8'h00, x);
    wr(2'd1, 8'hAA, s);
    expect_rise(s + p, "R7 pair survives other writes");
    wait_until(s + p + PL + 4);
    drain("R7 missing pulse");

    // R9: disarm / reconfigure attempts after arming are ignored
    do_reset();
    wr(2'd0, 8'h0C, x);
    wr(2'd0, 8'h05, w);
    wr(2'd0, 8'h00, x);
    wr(2'd0, 8'h0F, x);
    expect_rise(w + p, "R9 locked config");
    expect_rise(w + 2 * p + PL, "R9 still armed after pulse");
    wait_until(w + 2 * p + 2 * PL + 4);
    drain("R9 missing pulse");

    // R10: second key at a non-service address
    do_reset();
    wr(2'd0, 8'h05, w);
    wait_until(w + 30);
    wr(2'd1, 8'h55, x);
    wr(2'd2, 8'hAA, x);
    expect_rise(w + p, "R10 key at wrong address");
    wait_until(w + p + PL + 4);
    drain("R10 missing pulse");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 150000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule